// File: doc/BRIEF.md
# Bypassed Two-Read One-Write Register File

This block holds the architectural integer registers of a five-stage in-order pipeline and serves the decode stage. Two read ports return operand values combinationally from their addresses, and a single write port takes the result coming back from the write-back stage. Every storage update happens on the rising clock edge. No falling-edge write is used.

The write-back triple (enable, address, data) reaches the storage array only at the clock edge that ends the cycle in which it is presented. So the array alone would give a decode-stage read in that same cycle the stale contents. Each read port therefore has its own address comparator and a result multiplexer. When the port's address matches a live write-back, the multiplexer returns the incoming data instead of the array entry. Register 0 always reads as zero. It is never stored to and never bypassed.

Top module: `regfile_bypass`

## Requirements
- R1: While and after reset, with no write-back since, every register reads as zero on both ports.
- R2: A write-back with the enable high and a non-zero address is committed at the next rising edge. From the following cycle on, that register reads the written value until it is written again.
- R3: When read port A addresses the register targeted by a live write-back (enable high, non-zero address), port A returns the write-back data in that same cycle.
- R4: Read port B bypasses independently of port A under the same rule, including when both ports name the write-back target at once.
- R5: Address 0 reads as zero on either port at all times. A write-back to address 0 neither alters any register nor is bypassed.
- R6: With the write enable low, a matching write-back address has no effect: the port returns the stored value and nothing is committed.
- R7: A write-back changes only the register it addresses. All other registers keep their values.
- R8: Of two write-backs to the same register on consecutive edges, the later value is the one that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset that clears all registers |
| rd_addr_a | input | 5 | Read port A register index |
| rd_data_a | output | 32 | Read port A operand value |
| rd_addr_b | input | 5 | Read port B register index |
| rd_data_b | output | 32 | Read port B operand value |
| wb_en | input | 1 | Write-back valid |
| wb_addr | input | 5 | Write-back register index |
| wb_data | input | 32 | Write-back result value |

## Verification
A decode-stage read and a write-back commit can land in the same cycle on the same register. This is the case the bypass exists for. The bench provokes it by steering one or both read addresses onto the write-back address, in directed cases and in about a third of the random cycles. It also aims reads at address 0 and drives matches with the enable low. Each port is sampled mid-cycle and compared with a bench model. The model returns the live write-back data only for an enabled, non-zero match, and otherwise returns the contents committed at the previous edges.

// File: rtl/regfile_bypass_pkg.sv
package regfile_bypass_pkg;

    localparam int unsigned RF_DEPTH_DEFAULT = 32;
    localparam int unsigned RF_WIDTH_DEFAULT = 32;
    localparam int unsigned RF_READS_DEFAULT = 2;

    // Which source a read port forwards to its output.
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_WB    = 2'd1,
        SRC_ARRAY = 2'd2
    } rd_src_e;

endpackage

// File: rtl/rf_store_array.sv
module rf_store_array #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 32,
    parameter int unsigned NRD   = 2,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic [NRD-1:0][AW-1:0]     rd_addr,
    output logic [NRD-1:0][WIDTH-1:0]  rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    // Next-state: only non-zero entries are ever written.
    always_comb begin
        st_d = st_q;
        for (int unsigned i = 1; i < DEPTH; i++) begin
            if (wr_en && (wr_addr == AW'(i))) begin
                st_d.mem[i] = wr_data;
            end
        end
        st_d.mem[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Asynchronous read of the committed contents.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = st_q.mem[rd_addr[p]];
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_bypass_pkg::*;
#(
    parameter int unsigned AW    = 5,
    parameter int unsigned WIDTH = 32
) (
    input  logic [AW-1:0]    rd_addr,
    input  logic [WIDTH-1:0] arr_data,
    input  logic             wb_en,
    input  logic [AW-1:0]   wb_addr,
    input  logic [WIDTH-1:0] wb_data,
    output logic [WIDTH-1:0] rd_data
);

    rd_src_e src;
    logic    addr_is_zero;
    logic    hit;

    // Comparator: a live, non-zero write-back aimed at this address.
    always_comb begin
        addr_is_zero = (rd_addr == '0);
        hit          = wb_en && (wb_addr == rd_addr) && !addr_is_zero;
        if (addr_is_zero) begin
            src = SRC_ZERO;
        end else if (hit) begin
            src = SRC_WB;
        end else begin
            src = SRC_ARRAY;
        end
    end

    // Output multiplexer.
    always_comb begin
        unique case (src)
            SRC_ZERO:  rd_data = '0;
            SRC_WB:    rd_data = wb_data;
            SRC_ARRAY: rd_data = arr_data;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass
    import regfile_bypass_pkg::*;
#(
    parameter int unsigned DEPTH = RF_DEPTH_DEFAULT,
    parameter int unsigned WIDTH = RF_WIDTH_DEFAULT,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned NRD  = RF_READS_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr_a,
    output logic [WIDTH-1:0] rd_data_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [WIDTH-1:0] rd_data_b,
    input  logic             wb_en,
    input  logic [AW-1:0]    wb_addr,
    input  logic [WIDTH-1:0] wb_data
);

    logic [NRD-1:0][AW-1:0]    rd_addr_v;
    logic [NRD-1:0][WIDTH-1:0] arr_data_v;
    logic [NRD-1:0][WIDTH-1:0] rd_data_v;

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;

    rf_store_array #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .NRD   (NRD)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wb_en),
        .wr_addr (wb_addr),
        .wr_data (wb_data),
        .rd_addr (rd_addr_v),
        .rd_data (arr_data_v)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        rf_read_port #(
            .AW    (AW),
            .WIDTH (WIDTH)
        ) u_port (
            .rd_addr  (rd_addr_v[p]),
            .arr_data (arr_data_v[p]),
            .wb_en    (wb_en),
            .wb_addr  (wb_addr),
            .wb_data  (wb_data),
            .rd_data  (rd_data_v[p])
        );
    end

    assign rd_data_a = rd_data_v[0];
    assign rd_data_b = rd_data_v[1];

endmodule

// File: rtl/regfile_bypass_chk.sv
module regfile_bypass_chk #(
    parameter int unsigned AW    = 5,
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    rd_addr_a,
    input logic [WIDTH-1:0] rd_data_a,
    input logic [AW-1:0]    rd_addr_b,
    input logic [WIDTH-1:0] rd_data_b,
    input logic             wb_en,
    input logic [AW-1:0]    wb_addr,
    input logic [WIDTH-1:0] wb_data
);

    // R5: index zero always yields zero.
    a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0));
    a_r5_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    // R3 / R4: live non-zero match forwards the write-back data.
    a_r3_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_addr != '0 && rd_addr_a == wb_addr) |-> (rd_data_a == wb_data));
    a_r4_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_addr != '0 && rd_addr_b == wb_addr) |-> (rd_data_b == wb_data));

    // R2: a write committed at the last edge is visible on the next cycle.
    a_r2_commit_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wb_en) && $past(wb_addr) != '0
         && rd_addr_a == $past(wb_addr) && !(wb_en && wb_addr == rd_addr_a))
        |-> (rd_data_a == $past(wb_data)));

    // R6: without any write in this or the last cycle, a steady address gives steady data.
    a_r6_quiet_b: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !wb_en && !$past(wb_en) && $stable(rd_addr_b))
        |-> $stable(rd_data_b));

endmodule

bind regfile_bypass regfile_bypass_chk #(
    .AW    (AW),
    .WIDTH (WIDTH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .wb_en     (wb_en),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data)
);

// File: tb/regfile_bypass_tb_top.sv
`timescale 1ns/1ps
module regfile_bypass_tb_top;

    localparam int unsigned DEPTH = 32;
    localparam int unsigned WIDTH = 32;
    localparam int unsigned AW    = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [AW-1:0]    rd_addr_a, rd_addr_b, wb_addr;
    logic [WIDTH-1:0] rd_data_a, rd_data_b, wb_data;
    logic             wb_en;

    logic [WIDTH-1:0] model [DEPTH];
    int unsigned      n_checks = 0;
    int unsigned      n_fail   = 0;

    always #2.5 clk = ~clk;

    regfile_bypass dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_a (rd_addr_a),
        .rd_data_a (rd_data_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_b (rd_data_b),
        .wb_en     (wb_en),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data)
    );

    function automatic logic [WIDTH-1:0] expect_rd(input logic [AW-1:0] ra,
            input logic we, input logic [AW-1:0] wa, input logic [WIDTH-1:0] wd);
        if (ra == '0) return '0;
        if (we && wa == ra) return wd;
        return model[ra];
    endfunction

    function automatic string pick_tag(input logic [AW-1:0] ra, input logic we,
            input logic [AW-1:0] wa, input string bypass_tag);
        if (ra == '0) return "R5";
        if (we && wa == ra) return bypass_tag;
        if (!we && wa == ra) return "R6";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [WIDTH-1:0] got,
                         input logic [WIDTH-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle, check at the falling edge, update the model at the rising edge.
    task automatic cycle(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                         input logic we, input logic [AW-1:0] wa,
                         input logic [WIDTH-1:0] wd, input string ta, input string tb);
        rd_addr_a = ra; rd_addr_b = rb; wb_en = we; wb_addr = wa; wb_data = wd;
        @(negedge clk);
        check(ta, rd_data_a, expect_rd(ra, we, wa, wd));
        check(tb, rd_data_b, expect_rd(rb, we, wa, wd));
        @(posedge clk);
        if (we && wa != '0) model[wa] = wd;
        #1;
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            cycle(AW'(i), AW'(DEPTH - 1 - i), 1'b0, '0, '0, tag, tag);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        rst_n = 1'b0; wb_en = 1'b0; wb_addr = '0; wb_data = '0;
        rd_addr_a = '0; rd_addr_b = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, a write presented during reset is not kept.
        wb_en = 1'b1; wb_addr = 5'd9; wb_data = 32'hDEAD_BEEF;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        sweep("R1");

        // R3 and R4: both ports see a live write to the same register.
        cycle(5'd5, 5'd5, 1'b1, 5'd5, 32'h1234_5678, "R3", "R4");
        cycle(5'd5, 5'd5, 1'b0, 5'd0, '0, "R2", "R2");
        // R8: back-to-back writes to one register.
        cycle(5'd7, 5'd3, 1'b1, 5'd7, 32'hAAAA_0001, "R3", "R7");
        cycle(5'd2, 5'd7, 1'b1, 5'd7, 32'hBBBB_0002, "R7", "R4");
        cycle(5'd7, 5'd7, 1'b0, 5'd0, '0, "R8", "R8");
        // R5: write aimed at register zero.
        cycle(5'd0, 5'd0, 1'b1, 5'd0, 32'hFFFF_FFFF, "R5", "R5");
        cycle(5'd0, 5'd0, 1'b0, 5'd0, '0, "R5", "R5");
        // R6: matching address with enable low.
        cycle(5'd5, 5'd7, 1'b0, 5'd5, 32'h0BAD_0BAD, "R6", "R6");
        cycle(5'd5, 5'd7, 1'b0, 5'd7, 32'h0BAD_0BAD, "R6", "R6");
        sweep("R7");

        // Constrained random traffic with frequent collisions.
        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0]    wa, ra, rb;
            logic             we;
            logic [WIDTH-1:0] wd;
            we = ($urandom_range(0, 3) != 0);
            wa = ($urandom_range(0, 1) != 0) ? AW'($urandom_range(0, 7)) : AW'($urandom);
            wd = $urandom;
            ra = ($urandom_range(0, 2) == 0) ? wa : AW'($urandom_range(0, 7));
            rb = ($urandom_range(0, 2) == 0) ? wa : AW'($urandom);
            cycle(ra, rb, we, wa, wd, pick_tag(ra, we, wa, "R3"), pick_tag(rb, we, wa, "R4"));
        end
        sweep("R7");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule